// File: doc/BRIEF.md
# DMA Channel Count, Terminal Count and Status Unit

This unit holds the per-channel transfer state of a four-channel DMA engine. Each channel has a 16-bit memory address register and a 16-bit count word. The low 14 bits of the count word hold the number of transfers minus one. The top two bits name the transfer kind. The CPU programs these registers and a shared mode register through a small slave register port. It reads back every register and a status word through the same port.

An external arbiter, which is not part of this unit, reports each completed transfer with `xfer_done` and the channel number. An accepted transfer does three things: it steps the channel's address up by one, it steps the count down by one, and it drives `tc_out` when the count was zero. The transfer also drives `mark_out` whenever the remaining transfer count is a multiple of the mark interval. Terminal count flags in the status word are sticky, and a status read clears them. With autoload on, terminal count on channel 2 starts a one-cycle update in which channel 2 takes the address and count word held by channel 3.

Update state machine:
- States: `S_IDLE` and `S_UPDATE`.
- Transition from `S_IDLE` to `S_UPDATE`: taken when channel 2 reaches terminal count with autoload enabled.
- Transition from `S_UPDATE` to `S_IDLE`: taken unconditionally after one cycle.

Top module: `dma_tc_status`

## Requirements
- R1: The count word has this layout: bits [13:0] hold N-1 for N transfers, and bits [15:14] hold the transfer kind. Each accepted transfer decrements bits [13:0] and leaves bits [15:14] unchanged. After a zero count the field wraps to 3FFF.
- R2: Each accepted transfer increments the channel address register by one. `xfer_addr` shows the address of the channel selected by `xfer_ch`, with its value from before the increment.
- R3: `tc_out` is high during an accepted transfer whose count field is zero. The channel's flag, bit ch of the status word, is set in the next cycle.
- R4: A terminal count flag stays set until a status read or a reset.
- R5: A status read is `cfg_rd` with `cfg_addr`=8. It returns the terminal count flags in bits [3:0] and the update flag in bit 4. It clears the flags from the next cycle on. A flag that is set in the same cycle as the read survives.
- R6: The update flag (status bit 4) is high for the single update cycle. A status read does not clear it.
- R7: Autoload is mode bit 4. When it is set and channel 2 reaches terminal count, the next cycle is the update cycle. At the end of that cycle, channel 2's address and count word take channel 3's values. Channel 2 transfers and CPU writes to channel 2 are ignored during that cycle.
- R8: `mark_out` is high during an accepted transfer whose count field has bits [6:0] equal to zero. This marks every multiple of 128 transfers before the end of the block.
- R9: Mode bits [3:0] enable channels 0 to 3. A transfer on a disabled channel is ignored: no step, no `tc_out` and no `mark_out`.
- R10: `xfer_kind` shows bits [15:14] of the count word of the channel selected by `xfer_ch`.
- R11: A CPU write to a channel register in the same cycle as an accepted transfer on that channel wins over the step for that register.
- R12: Reset clears every address register, count word, mode bit and status bit. `cfg_addr` map: bits [2:1] select the channel, bit 0 selects the count word (1) or the address (0), and address 8 is mode (write) and status (read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | CPU register write strobe |
| cfg_rd | input | 1 | CPU register read strobe (a read of address 8 clears the flags) |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| xfer_done | input | 1 | One transfer completed this cycle |
| xfer_ch | input | 2 | Channel of the completed transfer |
| xfer_addr | output | 16 | Current address of the selected channel |
| xfer_kind | output | 2 | Transfer kind of the selected channel |
| tc_out | output | 1 | Terminal count during this transfer |
| mark_out | output | 1 | Mark pulse during this transfer |

## Verification
The assertions check the following on every cycle:
- the link from `tc_out` to the flag it sets;
- that flags hold when there is no status read;
- that a status read clears the flags;
- that terminal count implies a mark;
- that a disabled channel stays quiet;
- entry into the update cycle, its one-cycle length, and the copy from channel 3 into channel 2.

Other behaviour only the bench's scenarios can show, through its reference model:
- that the transfer count equals the loaded value plus one;
- the exact cycles in which marks fall over a 301-transfer block;
- that the count wraps and the kind bits are kept;
- that a CPU write wins over a step;
- that a flag set in the same cycle as a status read survives.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
    typedef enum logic [0:0] {
        S_IDLE   = 1'b0,
        S_UPDATE = 1'b1
    } upd_state_t;

    localparam int AUTO_DST = 2;
    localparam int AUTO_SRC = 3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int WORD_W    = 16,
    parameter int CNT_W     = 14,
    parameter int MARK_BITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr_en,
    input  logic              wr_word_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              step,
    input  logic              load,
    input  logic [WORD_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] word_q,
    output logic              cnt_zero,
    output logic              mark_hit
);
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = word_q[CNT_W-1:0] - CNT_W'(1);
    assign cnt_zero = (word_q[CNT_W-1:0] == '0);
    assign mark_hit = (word_q[MARK_BITS-1:0] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            word_q <= load_word;
        end else begin
            if (wr_addr_en)
                addr_q <= wdata;
            else if (step)
                addr_q <= addr_q + WORD_W'(1);
            if (wr_word_en)
                word_q <= wdata;
            else if (step)
                word_q <= {word_q[WORD_W-1:CNT_W], cnt_next};
        end
    end
endmodule

// File: rtl/dma_upd_ctrl.sv
module dma_upd_ctrl
    import dma_tc_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] tc_set,
    input  logic              status_rd,
    input  logic              auto_en,
    input  logic              auto_trig,
    output logic              upd_flag,
    output logic [NUM_CH-1:0] tc_flags
);
    upd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (auto_en && auto_trig) state_d = S_UPDATE;
            S_UPDATE: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:   upd_flag = 1'b0;
            S_UPDATE: upd_flag = 1'b1;
            default:  upd_flag = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         tc_flags <= '0;
        else if (status_rd) tc_flags <= tc_set;
        else                tc_flags <= tc_flags | tc_set;
    end
endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status
    import dma_tc_pkg::*;
#(
    parameter int NUM_CH        = 4,
    parameter int WORD_W        = 16,
    parameter int CNT_W         = 14,
    parameter int MARK_INTERVAL = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr,
    input  logic                      cfg_rd,
    input  logic [$clog2(NUM_CH)+1:0] cfg_addr,
    input  logic [WORD_W-1:0]         cfg_wdata,
    output logic [WORD_W-1:0]         cfg_rdata,
    input  logic                      xfer_done,
    input  logic [$clog2(NUM_CH)-1:0] xfer_ch,
    output logic [WORD_W-1:0]         xfer_addr,
    output logic [WORD_W-CNT_W-1:0]   xfer_kind,
    output logic                      tc_out,
    output logic                      mark_out
);
    localparam int CH_BITS   = $clog2(NUM_CH);
    localparam int AW        = CH_BITS + 2;
    localparam int MARK_BITS = $clog2(MARK_INTERVAL);

    logic [NUM_CH-1:0] en_q;
    logic              auto_q;
    logic              upd_flag;
    logic [NUM_CH-1:0] tc_flags;
    logic [NUM_CH-1:0] accept, zero_v, mark_v, tc_set;
    logic [WORD_W-1:0] addr_arr [NUM_CH];
    logic [WORD_W-1:0] word_arr [NUM_CH];
    logic              sel_ctrl, status_rd, mode_wr;
    logic [CH_BITS-1:0] reg_ch;

    assign sel_ctrl  = cfg_addr[AW-1];
    assign reg_ch    = cfg_addr[CH_BITS:1];
    assign status_rd = cfg_rd && sel_ctrl && (cfg_addr[AW-2:0] == '0);
    assign mode_wr   = cfg_wr && sel_ctrl && (cfg_addr[AW-2:0] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            auto_q <= 1'b0;
        end else if (mode_wr) begin
            en_q   <= cfg_wdata[NUM_CH-1:0];
            auto_q <= cfg_wdata[NUM_CH];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit, blocked;
        assign hit       = cfg_wr && !sel_ctrl && (reg_ch == CH_BITS'(i));
        assign blocked   = (i == AUTO_DST) && upd_flag;
        assign accept[i] = xfer_done && (xfer_ch == CH_BITS'(i)) && en_q[i] && !blocked;
        assign tc_set[i] = accept[i] && zero_v[i];

        dma_chan_regs #(
            .WORD_W   (WORD_W),
            .CNT_W    (CNT_W),
            .MARK_BITS(MARK_BITS)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_addr_en(hit && !cfg_addr[0]),
            .wr_word_en(hit && cfg_addr[0]),
            .wdata     (cfg_wdata),
            .step      (accept[i]),
            .load      (blocked),
            .load_addr (addr_arr[AUTO_SRC]),
            .load_word (word_arr[AUTO_SRC]),
            .addr_q    (addr_arr[i]),
            .word_q    (word_arr[i]),
            .cnt_zero  (zero_v[i]),
            .mark_hit  (mark_v[i])
        );
    end

    dma_upd_ctrl #(.NUM_CH(NUM_CH)) u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .tc_set   (tc_set),
        .status_rd(status_rd),
        .auto_en  (auto_q),
        .auto_trig(tc_set[AUTO_DST]),
        .upd_flag (upd_flag),
        .tc_flags (tc_flags)
    );

    assign tc_out    = |tc_set;
    assign mark_out  = |(accept & mark_v);
    assign xfer_addr = addr_arr[xfer_ch];
    assign xfer_kind = word_arr[xfer_ch][WORD_W-1:CNT_W];

    always_comb begin
        cfg_rdata = '0;
        if (sel_ctrl) begin
            if (cfg_addr[AW-2:0] == '0) begin
                cfg_rdata[NUM_CH-1:0] = tc_flags;
                cfg_rdata[NUM_CH]     = upd_flag;
            end
        end else if (cfg_addr[0]) begin
            cfg_rdata = word_arr[reg_ch];
        end else begin
            cfg_rdata = addr_arr[reg_ch];
        end
    end
endmodule

// File: rtl/dma_tc_status_chk.sv
module dma_tc_status_chk #(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_rd,
    input logic [$clog2(NUM_CH)+1:0] cfg_addr,
    input logic                      xfer_done,
    input logic [$clog2(NUM_CH)-1:0] xfer_ch,
    input logic                      tc_out,
    input logic                      mark_out,
    input logic [NUM_CH-1:0]         tc_flags,
    input logic [NUM_CH-1:0]         en_q,
    input logic                      auto_q,
    input logic                      upd_flag,
    input logic [WORD_W-1:0]         dst_addr,
    input logic [WORD_W-1:0]         dst_word,
    input logic [WORD_W-1:0]         src_addr,
    input logic [WORD_W-1:0]         src_word
);
    logic st_rd;
    assign st_rd = cfg_rd && (cfg_addr == {1'b1, {($clog2(NUM_CH)+1){1'b0}}});

    p_tc_then_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> mark_out);

    p_tc_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |=> tc_flags[$past(xfer_ch)]);

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rd |=> ((tc_flags & $past(tc_flags)) == $past(tc_flags)));

    p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd && !tc_out) |=> (tc_flags == '0));

    p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_flag |=> !upd_flag);

    p_upd_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_out && xfer_ch == 2 && auto_q && !upd_flag) |=> upd_flag);

    p_upd_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_flag |=> (dst_addr == $past(src_addr) && dst_word == $past(src_word)));

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !en_q[xfer_ch]) |-> (!tc_out && !mark_out));
endmodule

bind dma_tc_status dma_tc_status_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .xfer_done(xfer_done),
    .xfer_ch  (xfer_ch),
    .tc_out   (tc_out),
    .mark_out (mark_out),
    .tc_flags (tc_flags),
    .en_q     (en_q),
    .auto_q   (auto_q),
    .upd_flag (upd_flag),
    .dst_addr (addr_arr[2]),
    .dst_word (word_arr[2]),
    .src_addr (addr_arr[3]),
    .src_word (word_arr[3])
);

// File: tb/tb_dma_tc_status.sv
module tb_dma_tc_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        xfer_done = 1'b0;
    logic [1:0]  xfer_ch = '0;
    logic [15:0] xfer_addr;
    logic [1:0]  xfer_kind;
    logic        tc_out, mark_out;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [15:0] m_addr [4];
    logic [15:0] m_word [4];
    logic [3:0]  m_en, m_tc;
    logic        m_auto, m_upd;

    always #2 clk = ~clk;

    dma_tc_status dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xfer_done(xfer_done), .xfer_ch(xfer_ch), .xfer_addr(xfer_addr),
        .xfer_kind(xfer_kind), .tc_out(tc_out), .mark_out(mark_out)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = '0;
            m_word[i] = '0;
        end
        m_en = '0; m_tc = '0; m_auto = 0; m_upd = 0;
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [15:0] d, input logic xd, input logic [1:0] xc,
                       input string tag);
        logic acc, tce, mke, srd;
        logic [15:0] rexp;
        logic [3:0] set;
        logic [15:0] src_a, src_w;
        @(negedge clk);
        cfg_wr = wr; cfg_rd = rd; cfg_addr = a; cfg_wdata = d;
        xfer_done = xd; xfer_ch = xc;
        #1;
        acc = xd && m_en[xc] && !(m_upd && xc == 2);
        tce = acc && (m_word[xc][13:0] == 0);
        mke = acc && (m_word[xc][6:0] == 0);
        if (a == 4'd8)      rexp = {11'b0, m_upd, m_tc};
        else if (a[3])      rexp = 16'h0;
        else if (a[0])      rexp = m_word[a[2:1]];
        else                rexp = m_addr[a[2:1]];
        cmp(tag, "tc_out", tc_out, tce);
        cmp(tag, "mark_out", mark_out, mke);
        cmp(tag, "xfer_addr", xfer_addr, m_addr[xc]);
        cmp(tag, "xfer_kind", xfer_kind, m_word[xc][15:14]);
        cmp(tag, "cfg_rdata", cfg_rdata, rexp);
        @(posedge clk);
        srd = rd && a == 4'd8;
        set = '0;
        if (tce) set[xc] = 1'b1;
        src_a = m_addr[3]; src_w = m_word[3];
        if (acc) begin
            m_addr[xc] = m_addr[xc] + 16'd1;
            m_word[xc] = {m_word[xc][15:14], m_word[xc][13:0] - 14'd1};
        end
        if (wr && !a[3] && !(m_upd && a[2:1] == 2)) begin
            if (a[0]) m_word[a[2:1]] = d;
            else      m_addr[a[2:1]] = d;
        end
        if (m_upd) begin
            m_addr[2] = src_a;
            m_word[2] = src_w;
        end
        m_tc = srd ? set : (m_tc | set);
        m_upd = !m_upd && m_auto && set[2];
        if (wr && a == 4'd8) begin
            m_en = d[3:0];
            m_auto = d[4];
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [15:0] d, input string tag);
        cyc(1, 0, a, d, 0, 0, tag);
    endtask
    task automatic rreg(input logic [3:0] a, input string tag);
        cyc(0, 1, a, 0, 0, 0, tag);
    endtask
    task automatic xfer(input logic [1:0] c, input string tag);
        cyc(0, 0, 4'd0, 0, 1, c, tag);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R12 reset state
        rreg(4'd8, "R12");
        rreg(4'd0, "R12");
        rreg(4'd1, "R12");
        // R1 R2 R3 R10: three transfers on channel 0, kind 2
        wreg(4'd0, 16'h1000, "R2");
        wreg(4'd1, 16'h8002, "R1");
        wreg(4'd8, 16'h0001, "R1");
        xfer(0, "R2");
        xfer(0, "R1");
        xfer(0, "R3");
        rreg(4'd1, "R1");
        xfer(0, "R10");
        // R4 sticky, R5 clear
        cyc(0, 0, 4'd2, 0, 0, 0, "R4");
        rreg(4'd8, "R4");
        rreg(4'd8, "R5");
        // R9 disabled channel 1
        wreg(4'd2, 16'h0500, "R9");
        wreg(4'd3, 16'h0000, "R9");
        xfer(1, "R9");
        xfer(1, "R9");
        rreg(4'd3, "R9");
        rreg(4'd8, "R9");
        // R8 marks over a 301-transfer block, R10 kind 1
        wreg(4'd3, 16'h412C, "R10");
        wreg(4'd8, 16'h0003, "R8");
        for (int k = 0; k < 301; k++) xfer(1, "R8");
        rreg(4'd8, "R8");
        // R5 flag set in the read cycle survives
        wreg(4'd1, 16'h0000, "R5");
        cyc(0, 1, 4'd8, 0, 1, 0, "R5");
        rreg(4'd8, "R5");
        // R11 CPU write beats step
        wreg(4'd1, 16'h0005, "R11");
        cyc(1, 0, 4'd1, 16'h0010, 1, 0, "R11");
        rreg(4'd1, "R11");
        rreg(4'd0, "R11");
        // R7 R6 autoload
        wreg(4'd6, 16'h4000, "R7");
        wreg(4'd7, 16'h4001, "R7");
        wreg(4'd4, 16'h2000, "R7");
        wreg(4'd5, 16'h0001, "R7");
        wreg(4'd8, 16'h0014, "R7");
        xfer(2, "R7");
        xfer(2, "R7");
        cyc(1, 1, 4'd8, 16'h0014, 1, 2, "R6");
        rreg(4'd8, "R6");
        rreg(4'd4, "R7");
        rreg(4'd5, "R7");
        xfer(2, "R7");
        rreg(4'd4, "R7");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule